// File: doc/BRIEF.md
# Interrupt-on-Change Detector

The detector watches a bank of general-purpose input pins and records level transitions on them. Each pin has two enables: one that arms it for low-to-high transitions and one that arms it for high-to-low transitions. When an armed transition is seen on a pin, that pin's change flag is latched. The flags stay set until software clears them.

A summary flag is the OR of all per-pin flags. It is read-only and can only be cleared by clearing the per-pin flags. A summary enable gates the summary flag onto the interrupt request. Pin inputs are asynchronous: each passes through a two-flop synchronizer, and the last synchronized value is kept for edge comparison. A transition on a pin therefore shows up in its flag at the third rising clock edge after the pin changes.

The register port is a single-cycle write strobe with a 2-bit address and a combinational read. The map is:

| Address | Contents |
|---|---|
| 0 | rise enables |
| 1 | fall enables |
| 2 | pin flags |
| 3 | control (bit 0 = summary enable, bit 1 = summary flag, read-only; other bits read 0) |

Top module: `ioc_detector`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0. Synchronizer and history flops reset to 0.
- R2: A 0-to-1 transition on pin i, with rise-enable bit i set, sets flag bit i. The flag becomes visible at the third rising clock edge after the pin changes.
- R3: A 1-to-0 transition on pin i, with fall-enable bit i set, sets flag bit i, with the same latency as R2.
- R4: A pin with both enables set flags either transition. A pin with neither enable set never sets its flag. A transition in the direction that is not enabled leaves the flag unchanged.
- R5: A write to address 2 clears each flag bit whose write-data bit is 0 and leaves bits whose write-data bit is 1 unchanged. A write never sets a flag.
- R6: If a flag clear and a qualifying transition for the same bit land on the same clock edge, the flag stays set.
- R7: Control bit 1 reads as the OR of all flag bits. Writes to control bit 1 have no effect on it.
- R8: `irq_o` is high exactly when control bit 0 (summary enable) is 1 and at least one flag bit is set.
- R9: The enable registers (addresses 0 and 1) and control bit 0 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 8 | Monitored pin levels, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Single-pin scans step each pin through all four enable combinations with a rise and then a fall. These scans separate the rise path from the fall path and expose crossed or dropped enable bits. Multi-pin sweeps then apply 256 arithmetically spaced pin vectors under four enable masks, with expected flags computed from the previous and new pin values. They show whether edges on several pins at once are combined correctly and whether unarmed directions are ignored. Targeted sequences place a flag-clear write on the same edge as a new transition, write to the read-only summary bit, and toggle the summary enable. These sequences separate the set-wins rule and the gating from the plain OR.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef enum logic [1:0] {
    REG_RISE_EN = 2'd0,
    REG_FALL_EN = 2'd1,
    REG_FLAGS   = 2'd2,
    REG_CTRL    = 2'd3
  } ioc_reg_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SUM_BIT = 1;
endpackage

// File: rtl/ioc_rst_sync.sv
module ioc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] prev_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[SYNC_STAGES-2:0], pins_i[p]};
    end
    assign sync_o[p] = stage_q[SYNC_STAGES-1];
  end

  always_comb prev_d = sync_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/ioc_edge.sv
module ioc_edge #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  output logic [NUM_PINS-1:0] set_o
);
  logic [NUM_PINS-1:0] rise_hit;
  logic [NUM_PINS-1:0] fall_hit;

  always_comb begin
    rise_hit = sync_i & ~prev_i & rise_en_i;
    fall_hit = ~sync_i & prev_i & fall_en_i;
    set_o    = rise_hit | fall_hit;
  end

  // A set request on any bit requires a level change on that pin
  AST_SET_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o & ~(sync_i ^ prev_i)) == '0); // R4
  // A set request on any bit requires at least one enable on that pin
  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o & ~(rise_en_i | fall_en_i)) == '0); // R4
endmodule

// File: rtl/ioc_flags.sv
module ioc_flags #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_keep_i,
  output logic [NUM_PINS-1:0] flags_o
);
  logic [NUM_PINS-1:0] flags_q;
  logic [NUM_PINS-1:0] flags_d;
  logic [NUM_PINS-1:0] keep_mask;

  always_comb begin
    keep_mask = clr_we_i ? clr_keep_i : {NUM_PINS{1'b1}};
    flags_d   = (flags_q & keep_mask) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // A set request always lands, even when a clear is written on the same edge
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R6
  // Bits only rise where a set request was present
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0)); // R5
  // Bits only fall through a flag-register write
  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> (($past(flags_q) & ~flags_q) == '0)); // R5
endmodule

// File: rtl/ioc_regs.sv
module ioc_regs
  import ioc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] flags_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic                sum_en_o,
  output logic                flag_wr_o
);
  ioc_reg_e            sel;
  logic [NUM_PINS-1:0] rise_en_q, rise_en_d;
  logic [NUM_PINS-1:0] fall_en_q, fall_en_d;
  logic                sum_en_q,  sum_en_d;
  logic                rise_ce, fall_ce, ctrl_ce;

  always_comb begin
    sel       = ioc_reg_e'(addr_i);
    rise_ce   = we_i && (sel == REG_RISE_EN);
    fall_ce   = we_i && (sel == REG_FALL_EN);
    ctrl_ce   = we_i && (sel == REG_CTRL);
    flag_wr_o = we_i && (sel == REG_FLAGS);
    rise_en_d = rise_ce ? wdata_i : rise_en_q;
    fall_en_d = fall_ce ? wdata_i : fall_en_q;
    sum_en_d  = ctrl_ce ? wdata_i[CTRL_EN_BIT] : sum_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      sum_en_q  <= 1'b0;
    end else begin
      rise_en_q <= rise_en_d;
      fall_en_q <= fall_en_d;
      sum_en_q  <= sum_en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_RISE_EN: rdata_o = rise_en_q;
      REG_FALL_EN: rdata_o = fall_en_q;
      REG_FLAGS:   rdata_o = flags_i;
      REG_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = sum_en_q;
        rdata_o[CTRL_SUM_BIT] = |flags_i;
      end
    endcase
  end

  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign sum_en_o  = sum_en_q;

  // Enables change only through a write to their own address
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ce |=> $stable(rise_en_q)); // R9
endmodule

// File: rtl/ioc_detector.sv
module ioc_detector #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  output logic                irq_o
);
  logic                rst_n_s;
  logic [NUM_PINS-1:0] sync_v, prev_v, set_v, flags_v, rise_en, fall_en;
  logic                sum_en, flag_wr;

  ioc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync_o(rst_n_s)
  );

  ioc_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .pins_i(pins_i), .sync_o(sync_v), .prev_o(prev_v)
  );

  ioc_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .sync_i(sync_v), .prev_i(prev_v),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .set_o(set_v)
  );

  ioc_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .set_i(set_v), .clr_we_i(flag_wr),
    .clr_keep_i(reg_wdata_i), .flags_o(flags_v)
  );

  ioc_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flags_i(flags_v), .rdata_o(reg_rdata_o),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .sum_en_o(sum_en),
    .flag_wr_o(flag_wr)
  );

  assign irq_o = sum_en & (|flags_v);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> sum_en); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (flags_v != '0)); // R7
endmodule

// File: tb/ioc_detector_test.sv
`timescale 1ns/1ps
module ioc_detector_test;
  localparam int N = 8;
  localparam real HALF = 2.0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pins;
  logic         we;
  logic [1:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [N-1:0] model_prev;

  always #(HALF) clk = ~clk;

  ioc_detector #(.NUM_PINS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  // Change pins and wait until the third rising edge has passed
  task automatic drive(input logic [N-1:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] d;
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    model_prev = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0);

    // R9 readback
    wr(0, 8'h5A); rd(0, d); check("R9 rise_en", d, 8'h5A);
    wr(1, 8'hC3); rd(1, d); check("R9 fall_en", d, 8'hC3);
    wr(3, 8'h01); rd(3, d); check("R9 ctrl en", d, 8'h01);
    wr(3, 8'h00);

    // R2 R3 R4 per-pin scan over all four enable modes
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        wr(0, m[0] ? (8'h01 << i) : 8'h00);
        wr(1, m[1] ? (8'h01 << i) : 8'h00);
        drive(8'h01 << i);
        rd(2, d); check("R2 R4 rise", d, m[0] ? (8'h01 << i) : 8'h00);
        wr(2, 8'h00);
        drive(8'h00);
        rd(2, d); check("R3 R4 fall", d, m[1] ? (8'h01 << i) : 8'h00);
        wr(2, 8'h00);
      end
    end
    model_prev = '0;

    // Multi-pin sweep with arithmetic pin vectors
    wr(3, 8'h01);
    for (int c = 0; c < 4; c++) begin
      logic [N-1:0] ren, fen;
      ren = 8'hA5 ^ N'(c * 8'h33);
      fen = 8'h3C ^ N'(c * 8'h5F);
      wr(0, ren); wr(1, fen);
      for (int k = 0; k < 256; k++) begin
        logic [N-1:0] v, exp;
        v   = N'(k * 37 + c * 11);
        exp = (~model_prev & v & ren) | (model_prev & ~v & fen);
        drive(v);
        check("R8 irq sweep", irq, (exp != 0));
        rd(2, d); check("R2 R3 R4 sweep flags", d, exp);
        rd(3, d); check("R7 summary", d[1], (exp != 0));
        wr(2, 8'h00);
        rd(2, d); check("R5 cleared", d, 0);
        model_prev = v;
      end
    end

    // R5 partial clear, write of ones never sets
    wr(0, 8'hFF); wr(1, 8'hFF);
    drive(~model_prev); model_prev = ~model_prev;
    rd(2, d); check("R5 all set", d, 8'hFF);
    wr(2, 8'hF0); rd(2, d); check("R5 partial clear", d, 8'hF0);
    wr(2, 8'hFF); rd(2, d); check("R5 ones keep", d, 8'hF0);
    wr(2, 8'h00); wr(2, 8'hFF); rd(2, d); check("R5 no set by write", d, 8'h00);

    // R7 write to summary bit ignored; R8 gating
    drive(model_prev ^ 8'h04); model_prev = model_prev ^ 8'h04;
    wr(3, 8'h02); rd(3, d); check("R7 summary read-only", d, 8'h02);
    check("R8 irq gated off", irq, 0);
    wr(3, 8'h01); @(negedge clk); check("R8 irq on", irq, 1);
    wr(2, 8'h00); @(negedge clk); check("R8 irq drops", irq, 0);
    rd(3, d); check("R7 summary cleared", d, 8'h01);

    // R6 clear on same edge as new transition
    drive(model_prev ^ 8'h10); model_prev = model_prev ^ 8'h10;
    @(negedge clk); pins = model_prev ^ 8'h01; model_prev = model_prev ^ 8'h01;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 2; wdata = 8'h00;
    @(negedge clk); we = 1'b0;
    rd(2, d); check("R6 set wins over clear", d, 8'h01);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule